// File: doc/BRIEF.md
# Initialization Block Fetch Sequencer

This block reads a setup table out of host memory by acting as a bus master. Bus ownership comes in short tenures. In each tenure the block requests the bus, waits for a grant, moves exactly two 32-bit words, and then gives the bus back. It asks for the bus again until every needed word has been read. Each word that is read is handed to the consumer together with its position in the table.

Two inputs are sampled on the start pulse and held for the whole fetch. The structure-size input picks the table size. A wide table uses 32-bit structures: it holds seven words and needs four tenures. A narrow table uses 16-bit structures: it is delivered as six words over three tenures. A wide fetch reads an eighth word that is not needed, and that word is never forwarded. The address-mode input picks the address scheme. In non-burst mode each word gets its own address phase. In burst mode each tenure has a single address phase followed by two data phases.

Top module: `ibf_fetch_seq`

## Requirements
- R1: While reset is applied, and until the first start, all of these outputs stay low: req_o, frame_o, addr_phase_o, word_valid_o, done_o and busy_o.
- R2: A tenure begins with req_o high and frame_o low until gnt_i is seen. The address phase follows in the next cycle. The tenure then accepts exactly two rvalid_i data completions and drops frame_o.
- R3: When wide_mode_i=1 at start, the fetch uses four tenures and eight transfers.
- R4: When wide_mode_i=0 at start, the fetch uses three tenures and six transfers.
- R5: The word address is the start address with bits [1:0] forced to 0, plus 4 for each completed transfer, counted across all tenures. It is shown on addr_o.
- R6: When burst_en_i=0, every transfer has its own one-cycle addr_phase_o. frame_o is low for exactly one cycle between the two transfers of a tenure.
- R7: When burst_en_i=1, each tenure has a single addr_phase_o cycle, with addr_o[1:0]=0. frame_o stays high from that cycle until the second data completion.
- R8: word_valid_o is high in the cycle of a data completion only if word_idx_o is below the kept count (7 for wide, 6 for narrow). It then carries word_data_o=rdata_i and word_idx_o = the transfer number, counted from 0. A wide fetch's eighth word (index 7) is read but never delivered.
- R9: done_o pulses for exactly one cycle, in the cycle after the final data completion. busy_o is low in the next cycle.
- R10: start_i is ignored while busy_o is high. The start address and both mode inputs are sampled only on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a fetch (accepted only when idle) |
| base_addr_i | input | 32 | Table start address in host memory |
| wide_mode_i | input | 1 | 1 = 32-bit structures (7 words), 0 = 16-bit structures (6 words) |
| burst_en_i | input | 1 | 1 = burst address scheme, 0 = one address phase per word |
| req_o | output | 1 | Bus request |
| gnt_i | input | 1 | Bus grant |
| addr_o | output | 32 | Current word address |
| frame_o | output | 1 | Transaction active |
| addr_phase_o | output | 1 | Address-phase strobe |
| rdata_i | input | 32 | Read data from the bus |
| rvalid_i | input | 1 | Data phase completes this cycle |
| word_valid_o | output | 1 | Delivered word is valid |
| word_data_o | output | 32 | Delivered word |
| word_idx_o | output | 4 | Index of the delivered word |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Fetch in progress |

## Verification
All four combinations of structure size and address scheme are run. The wide/narrow pairs separate the tenure counts and show that the surplus eighth read is dropped. The burst/non-burst pairs separate the single-strobe, continuous-frame tenure from the two-strobe tenure that has a frame gap. Grant delays and random wait states on rvalid_i test whether transfer counting follows data completions rather than elapsed cycles. A misaligned start address and a start pulse sent in mid-fetch, with different mode inputs, check the address masking and the rule that a running fetch ignores a new start.

// File: rtl/ibf_pkg.sv
package ibf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_GAP  = 3'd4,
    ST_DONE = 3'd5
  } ibf_state_e;
endpackage

// File: rtl/ibf_rst_sync.sv
module ibf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ibf_plan.sv
module ibf_plan #(
  parameter int WORDS_WIDE   = 7,
  parameter int WORDS_NARROW = 6,
  parameter int XPT          = 2,
  parameter int CNT_W        = 4
) (
  input  logic             wide_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] keep_o
);
  localparam int TEN_WIDE     = (WORDS_WIDE + XPT - 1) / XPT;
  localparam int TEN_NARROW   = (WORDS_NARROW + XPT - 1) / XPT;
  localparam int TOTAL_WIDE   = TEN_WIDE * XPT;
  localparam int TOTAL_NARROW = TEN_NARROW * XPT;

  always_comb begin
    if (wide_i) begin
      total_o = CNT_W'(TOTAL_WIDE);
      keep_o  = CNT_W'(WORDS_WIDE);
    end else begin
      total_o = CNT_W'(TOTAL_NARROW);
      keep_o  = CNT_W'(WORDS_NARROW);
    end
  end
endmodule

// File: rtl/ibf_addr.sv
module ibf_addr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load_i | step_i;
    addr_d  = addr_q;
    if (load_i)      addr_d = {base_i[ADDR_W-1:2], 2'b00};
    else if (step_i) addr_d = addr_q + ADDR_W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = {addr_q[ADDR_W-1:2], 2'b00};
endmodule

// File: rtl/ibf_ctrl.sv
module ibf_ctrl
  import ibf_pkg::*;
#(
  parameter int XPT   = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             gnt_i,
  input  logic             rvalid_i,
  input  logic             burst_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] keep_i,
  output logic             req_o,
  output logic             addr_phase_o,
  output logic             frame_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             load_o,
  output logic             step_o,
  output logic             deliver_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam int BEAT_W = $clog2(XPT + 1);

  ibf_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0]  xfer_q, xfer_d;
  logic              last_beat;
  logic [CNT_W-1:0]  xfer_inc;

  assign last_beat = (beat_q == BEAT_W'(XPT - 1));
  assign xfer_inc  = xfer_q + CNT_W'(1);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    xfer_d  = xfer_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_REQ;
          beat_d  = '0;
          xfer_d  = '0;
        end
      end
      ST_REQ:  if (gnt_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (rvalid_i) begin
          xfer_d = xfer_inc;
          if (last_beat) begin
            beat_d  = '0;
            state_d = (xfer_inc == total_i) ? ST_DONE : ST_REQ;
          end else begin
            beat_d  = beat_q + BEAT_W'(1);
            state_d = burst_i ? ST_DATA : ST_GAP;
          end
        end
      end
      ST_GAP:  state_d = ST_ADDR;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      xfer_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      xfer_q  <= xfer_d;
    end
  end

  always_comb begin
    req_o        = (state_q == ST_REQ);
    addr_phase_o = (state_q == ST_ADDR);
    frame_o      = (state_q == ST_ADDR) || (state_q == ST_DATA);
    done_o       = (state_q == ST_DONE);
    busy_o       = (state_q != ST_IDLE);
    load_o       = (state_q == ST_IDLE) && start_i;
    step_o       = (state_q == ST_DATA) && rvalid_i;
    deliver_o    = step_o && (xfer_q < keep_i);
    idx_o        = xfer_q;
  end
endmodule

// File: rtl/ibf_fetch_seq.sv
module ibf_fetch_seq #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int WORDS_WIDE   = 7,
  parameter int WORDS_NARROW = 6,
  parameter int XPT          = 2,
  parameter int IDX_W        = $clog2(((WORDS_WIDE + XPT - 1) / XPT) * XPT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              wide_mode_i,
  input  logic              burst_en_i,
  output logic              req_o,
  input  logic              gnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              frame_o,
  output logic              addr_phase_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rvalid_i,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_data_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              done_o,
  output logic              busy_o
);
  logic             rst_n_s;
  logic             wide_q, burst_q;
  logic             load, step, deliver;
  logic [IDX_W-1:0] total, keep;

  ibf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wide_q  <= 1'b0;
      burst_q <= 1'b0;
    end else if (load) begin
      wide_q  <= wide_mode_i;
      burst_q <= burst_en_i;
    end
  end

  ibf_plan #(
    .WORDS_WIDE(WORDS_WIDE), .WORDS_NARROW(WORDS_NARROW),
    .XPT(XPT), .CNT_W(IDX_W)
  ) u_plan (
    .wide_i(wide_q), .total_o(total), .keep_o(keep)
  );

  ibf_addr #(.ADDR_W(ADDR_W), .STEP(DATA_W / 8)) u_addr (
    .clk(clk), .rst_n(rst_n_s), .load_i(load), .base_i(base_addr_i),
    .step_i(step), .addr_o(addr_o)
  );

  ibf_ctrl #(.XPT(XPT), .CNT_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .gnt_i(gnt_i),
    .rvalid_i(rvalid_i), .burst_i(burst_q), .total_i(total), .keep_i(keep),
    .req_o(req_o), .addr_phase_o(addr_phase_o), .frame_o(frame_o),
    .done_o(done_o), .busy_o(busy_o), .load_o(load), .step_o(step),
    .deliver_o(deliver), .idx_o(word_idx_o)
  );

  assign word_valid_o = deliver;
  assign word_data_o  = rdata_i;
endmodule

// File: rtl/ibf_fetch_seq_chk.sv
module ibf_fetch_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int KEEP_MAX = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_o,
  input logic              gnt_i,
  input logic              frame_o,
  input logic              addr_phase_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rvalid_i,
  input logic              word_valid_o,
  input logic [IDX_W-1:0]  word_idx_o,
  input logic              done_o,
  input logic              busy_o
);
  logic [2:0] ten_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ten_cnt <= '0;
    else if (req_o)                               ten_cnt <= '0;
    else if (rvalid_i && frame_o && !addr_phase_o) ten_cnt <= ten_cnt + 3'd1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!req_o && !frame_o && !addr_phase_o && !word_valid_o && !done_o));

  p_req_no_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !frame_o);

  p_grant_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> addr_phase_o);

  p_two_per_tenure_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ten_cnt <= 3'd2);

  p_strobe_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase_o |-> frame_o);

  p_strobe_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase_o |-> (addr_o[1:0] == 2'b00));

  p_keep_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (word_idx_o < IDX_W'(KEEP_MAX)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

bind ibf_fetch_seq ibf_fetch_seq_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .KEEP_MAX(WORDS_WIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .gnt_i(gnt_i), .frame_o(frame_o),
  .addr_phase_o(addr_phase_o), .addr_o(addr_o), .rvalid_i(rvalid_i),
  .word_valid_o(word_valid_o), .word_idx_o(word_idx_o), .done_o(done_o),
  .busy_o(busy_o)
);

// File: tb/ibf_fetch_seq_tb.sv
`timescale 1ns/1ps
module ibf_fetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic        wide_mode_i = 1'b0;
  logic        burst_en_i = 1'b0;
  logic        gnt_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic        rvalid_i = 1'b0;
  logic        req_o, frame_o, addr_phase_o, word_valid_o, done_o, busy_o;
  logic [31:0] addr_o, word_data_o;
  logic [3:0]  word_idx_o;

  ibf_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .wide_mode_i(wide_mode_i), .burst_en_i(burst_en_i), .req_o(req_o),
    .gnt_i(gnt_i), .addr_o(addr_o), .frame_o(frame_o),
    .addr_phase_o(addr_phase_o), .rdata_i(rdata_i), .rvalid_i(rvalid_i),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o),
    .word_idx_o(word_idx_o), .done_o(done_o), .busy_o(busy_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int          m_ph = 0;     // 0 idle 1 req 2 addr 3 data 4 gap 5 done
  int          m_k = 0;
  bit          m_wide = 0, m_burst = 0;
  logic [31:0] m_addr = '0;
  bit          model_on = 0;

  function automatic int m_total(); return m_wide ? 8 : 6; endfunction
  function automatic int m_keep();  return m_wide ? 7 : 6; endfunction

  always @(posedge clk) begin
    if (!model_on) begin
      m_ph <= 0; m_k <= 0; m_addr <= '0;
    end else begin
      case (m_ph)
        0: if (start_i) begin
             m_ph <= 1; m_k <= 0; m_addr <= base_addr_i & 32'hFFFF_FFFC;
             m_wide <= wide_mode_i; m_burst <= burst_en_i;
           end
        1: if (gnt_i) m_ph <= 2;
        2: m_ph <= 3;
        3: if (rvalid_i) begin
             m_k <= m_k + 1;
             m_addr <= m_addr + 32'd4;
             if (m_k % 2 == 1) m_ph <= (m_k + 1 == m_total()) ? 5 : 1;
             else              m_ph <= m_burst ? 3 : 4;
           end
        4: m_ph <= 2;
        default: m_ph <= 0;
      endcase
    end
  end

  // bus responder and per-cycle compare
  int  gdelay = 0, gcnt = 0, wmode = 0;
  int  lfsr = 32'h1ACE;
  int  n_words = 0, n_ten = 0, n_strobe = 0, n_done = 0, last_idx = -1;
  bit  prev_req = 0;

  always @(negedge clk) begin
    cyc++;
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    if (req_o) gcnt++; else gcnt = 0;
    gnt_i    = req_o && (gcnt > gdelay);
    rvalid_i = frame_o && !addr_phase_o && (wmode == 0 || lfsr[0]);
    rdata_i  = 32'hD000_0000 | cyc;
    #1;
    if (model_on) begin
      string tg;
      tg = m_burst ? "R7" : "R6";
      chk(req_o == (m_ph == 1), "R2 req", req_o, m_ph == 1);
      chk(addr_phase_o == (m_ph == 2), tg, addr_phase_o, m_ph == 2);
      chk(frame_o == (m_ph == 2 || m_ph == 3), tg, frame_o, m_ph == 2 || m_ph == 3);
      chk(addr_o == m_addr, "R5 addr", addr_o, m_addr);
      chk(word_valid_o == (m_ph == 3 && rvalid_i && m_k < m_keep()), "R8 valid",
          word_valid_o, m_ph == 3 && rvalid_i && m_k < m_keep());
      if (word_valid_o) begin
        chk(word_idx_o == m_k[3:0], "R8 idx", word_idx_o, m_k);
        chk(word_data_o == rdata_i, "R8 data", word_data_o, rdata_i);
      end
      chk(done_o == (m_ph == 5), "R9 done", done_o, m_ph == 5);
      chk(busy_o == (m_ph != 0), "R10 busy", busy_o, m_ph != 0);
      if (word_valid_o) begin n_words++; last_idx = word_idx_o; end
      if (req_o && !prev_req) n_ten++;
      if (addr_phase_o) n_strobe++;
      if (done_o) n_done++;
      prev_req = req_o;
    end
  end

  task automatic run_fetch(input logic [31:0] base, input bit wide, input bit burst,
                           input int gd, input int wm, input bit poke);
    int ten_exp, xf_exp, keep_exp, strobe_exp;
    @(negedge clk);
    gdelay = gd; wmode = wm;
    n_words = 0; n_ten = 0; n_strobe = 0; n_done = 0; last_idx = -1;
    base_addr_i = base; wide_mode_i = wide; burst_en_i = burst; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    base_addr_i = ~base; wide_mode_i = ~wide; burst_en_i = ~burst;
    if (poke) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;  // R10: must be ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (n_done == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    ten_exp    = wide ? 4 : 3;
    xf_exp     = ten_exp * 2;
    keep_exp   = wide ? 7 : 6;
    strobe_exp = burst ? ten_exp : xf_exp;
    chk(n_ten == ten_exp, wide ? "R3 tenures" : "R4 tenures", n_ten, ten_exp);
    chk(n_strobe == strobe_exp, burst ? "R7 strobes" : "R6 strobes", n_strobe, strobe_exp);
    chk(n_words == keep_exp, "R8 words kept", n_words, keep_exp);
    chk(last_idx == keep_exp - 1, "R8 last index", last_idx, keep_exp - 1);
    chk(n_done == 1, "R9 one done", n_done, 1);
    chk(busy_o == 1'b0, poke ? "R10 idle after ignored start" : "R9 idle", busy_o, 0);
    chk(addr_o == ((base & 32'hFFFF_FFFC) + 4 * xf_exp), "R5 final addr", addr_o,
        (base & 32'hFFFF_FFFC) + 4 * xf_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_o && !frame_o && !addr_phase_o, "R1 reset bus", {req_o, frame_o, addr_phase_o}, 0);
    chk(!word_valid_o && !done_o && !busy_o, "R1 reset out", {word_valid_o, done_o, busy_o}, 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !req_o, "R1 idle after release", {busy_o, req_o}, 0);
    run_fetch(32'h0000_1000, 1, 1, 0, 0, 0);
    run_fetch(32'h0000_2000, 1, 0, 2, 1, 0);
    run_fetch(32'h0000_3000, 0, 1, 1, 1, 0);
    run_fetch(32'h0000_4000, 0, 0, 0, 0, 0);
    run_fetch(32'h8000_0103, 1, 1, 3, 1, 1);
    run_fetch(32'hFFFF_FFC2, 0, 0, 1, 1, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule